// File: doc/BRIEF.md
# Saturating Signed Adder/Subtractor with Sticky Overflow Flags

This block adds or subtracts two signed operands of `DATA_W` bits (32 by default). It sign-extends both operands and forms the exact sum or difference one bit wider. It then clamps that value to the signed `DATA_W`-bit range. The clamped value appears on a registered output one clock after the operation is issued, together with a one-cycle done pulse.

Alongside the result, the block keeps four status bits. The overflow bit shows whether the last operation clamped. The early-overflow bit is the XOR of the top two bits of the exact value inside the `DATA_W`-bit field. It warns that the value is near or past the edge of the range.

Each of these two bits has a sticky twin. A sticky twin accumulates across operations and is cleared only by reset or by a synchronous clear input. Status bits change only on cycles where the operation strobe is high.

Top module: `sat_addsub`

## Requirements
- R1: When the exact value of `a + b` (op_sub = 0) or `a - b` (op_sub = 1), with both operands read as signed two's complement, lies in [-2^(W-1), 2^(W-1)-1], res_q carries its low W bits.
- R2: When the exact value is above 2^(W-1)-1, res_q is 0 followed by W-1 ones (0x7FFFFFFF for W = 32).
- R3: When the exact value is below -2^(W-1), res_q is 1 followed by W-1 zeros (0x80000000 for W = 32).
- R4: flg_ovf is set by an operation that clamps and is cleared by an operation that does not clamp.
- R5: flg_sovf is set by an operation that clamps. Otherwise it keeps its value, apart from the clear in R9.
- R6: flg_aovf equals bit W-1 XOR bit W-2 of the exact value, taken in two's complement before clamping.
- R7: On every operation, flg_saovf becomes its old value ORed with the new early-overflow bit.
- R8: A cycle with op_valid low leaves res_q and all four flags unchanged.
- R9: sticky_clr high at a clock edge zeroes flg_sovf and flg_saovf, even if an operation at that edge would set them. flg_ovf and flg_aovf still update from that operation.
- R10: Results and flags from an operation issued at an edge are visible after that edge. res_done is high for exactly the cycle following each edge with op_valid high.
- R11: After reset, res_q, res_done and all four flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_sub | input | 1 | 0 = add, 1 = subtract (a - b) |
| opnd_a | input | DATA_W | Signed operand a |
| opnd_b | input | DATA_W | Signed operand b |
| sticky_clr | input | 1 | Synchronous clear of both sticky flags |
| res_q | output | DATA_W | Registered clamped result |
| res_done | output | 1 | One-cycle pulse marking a new result |
| flg_ovf | output | 1 | Last operation clamped |
| flg_sovf | output | 1 | Sticky copy of the overflow bit |
| flg_aovf | output | 1 | Early-overflow bit of the last operation |
| flg_saovf | output | 1 | Sticky copy of the early-overflow bit |

## Verification
Every output is due one clock edge after the operation that produces it: the result, the done pulse, both direct flags and both sticky flags. The bench drives inputs on the falling edge. On the next falling edge it compares the outputs with a model that it updated when it drove those inputs.

Idle cycles and clear cycles follow the same one-edge rule. This lets the sweep issue one operation per cycle with no gaps, and every comparison falls half a period after the edge that changed the output.

// File: rtl/sat_pkg.sv
package sat_pkg;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } sat_op_e;

  typedef struct packed {
    logic ovf;
    logic sovf;
    logic aovf;
    logic saovf;
  } sat_flags_t;

endpackage

// File: rtl/sat_arith.sv
module sat_arith #(
  parameter int W = 32
) (
  input  logic         op_sub,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W:0]   exact,
  output logic [W-1:0] clamped,
  output logic         sat_evt,
  output logic         adv_evt
);
  import sat_pkg::*;

  localparam int XW = W + 1;
  localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

  function automatic logic [XW-1:0] f_exact(input sat_op_e op,
                                            input logic [W-1:0] x,
                                            input logic [W-1:0] y);
    logic [XW-1:0] xs;
    logic [XW-1:0] ys;
    xs = {x[W-1], x};
    ys = {y[W-1], y};
    return (op == OP_SUB) ? (xs - ys) : (xs + ys);
  endfunction

  function automatic logic f_out_of_range(input logic [XW-1:0] v);
    return v[XW-1] ^ v[XW-2];
  endfunction

  function automatic logic [W-1:0] f_clamp(input logic [XW-1:0] v);
    if (!f_out_of_range(v)) return v[W-1:0];
    return v[XW-1] ? NEG_LIM : POS_LIM;
  endfunction

  function automatic logic f_advance(input logic [XW-1:0] v);
    return v[W-1] ^ v[W-2];
  endfunction

  always_comb begin
    exact   = f_exact(sat_op_e'(op_sub), a, b);
    clamped = f_clamp(exact);
    sat_evt = f_out_of_range(exact);
    adv_evt = f_advance(exact);
  end

endmodule

// File: rtl/sat_flags.sv
module sat_flags (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                upd,
  input  logic                clr,
  input  logic                sat_evt,
  input  logic                adv_evt,
  output sat_pkg::sat_flags_t flags
);
  import sat_pkg::*;

  sat_flags_t cur;
  sat_flags_t nxt;

  always_comb begin
    nxt = cur;
    if (upd) begin
      nxt.ovf   = sat_evt;
      nxt.aovf  = adv_evt;
      nxt.sovf  = cur.sovf | sat_evt;
      nxt.saovf = cur.saovf | adv_evt;
    end
    if (clr) begin
      nxt.sovf  = 1'b0;
      nxt.saovf = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= '0;
    else        cur <= nxt;
  end

  assign flags = cur;

endmodule

// File: rtl/sat_out_stage.sv
module sat_out_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         done
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q    <= '0;
      done <= 1'b0;
    end else begin
      done <= upd;
      if (upd) q <= d;
    end
  end

endmodule

// File: rtl/sat_addsub.sv
module sat_addsub #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              op_sub,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              sticky_clr,
  output logic [DATA_W-1:0] res_q,
  output logic              res_done,
  output logic              flg_ovf,
  output logic              flg_sovf,
  output logic              flg_aovf,
  output logic              flg_saovf
);
  import sat_pkg::*;

  logic [DATA_W:0]   arith_exact;
  logic [DATA_W-1:0] arith_clamped;
  logic              arith_sat;
  logic              arith_adv;
  sat_flags_t        flag_q;

  sat_arith #(.W(DATA_W)) u_arith (
    .op_sub  (op_sub),
    .a       (opnd_a),
    .b       (opnd_b),
    .exact   (arith_exact),
    .clamped (arith_clamped),
    .sat_evt (arith_sat),
    .adv_evt (arith_adv)
  );

  sat_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (op_valid),
    .clr     (sticky_clr),
    .sat_evt (arith_sat),
    .adv_evt (arith_adv),
    .flags   (flag_q)
  );

  sat_out_stage #(.W(DATA_W)) u_out (
    .clk  (clk),
    .rst_n(rst_n),
    .upd  (op_valid),
    .d    (arith_clamped),
    .q    (res_q),
    .done (res_done)
  );

  assign flg_ovf   = flag_q.ovf;
  assign flg_sovf  = flag_q.sovf;
  assign flg_aovf  = flag_q.aovf;
  assign flg_saovf = flag_q.saovf;

endmodule

// File: rtl/sat_addsub_chk.sv
module sat_addsub_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_valid,
  input logic         sticky_clr,
  input logic         sat_evt,
  input logic         adv_evt,
  input logic [W-1:0] res_q,
  input logic         res_done,
  input logic         flg_ovf,
  input logic         flg_sovf,
  input logic         flg_aovf,
  input logic         flg_saovf
);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_done); // R10
  AST_NO_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !res_done); // R10
  AST_OVF_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> (flg_ovf == $past(sat_evt))); // R4
  AST_AOVF_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> (flg_aovf == $past(adv_evt))); // R6
  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && sat_evt && !sticky_clr) |=> flg_sovf); // R5
  AST_STICKY_ADV_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && adv_evt && !sticky_clr) |=> flg_saovf); // R7
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    sticky_clr |=> (!flg_sovf && !flg_saovf)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !sticky_clr) |=> ($stable(res_q) && $stable(flg_ovf) &&
      $stable(flg_sovf) && $stable(flg_aovf) && $stable(flg_saovf))); // R8
  AST_CLAMP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && flg_ovf) |-> (res_q[W-2:0] == {(W-1){~res_q[W-1]}})); // R2

endmodule

bind sat_addsub sat_addsub_chk #(.W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid   (op_valid),
  .sticky_clr (sticky_clr),
  .sat_evt    (arith_sat),
  .adv_evt    (arith_adv),
  .res_q      (res_q),
  .res_done   (res_done),
  .flg_ovf    (flg_ovf),
  .flg_sovf   (flg_sovf),
  .flg_aovf   (flg_aovf),
  .flg_saovf  (flg_saovf)
);

// File: tb/sim_sat_addsub.sv
`timescale 1ns/1ps
module sim_sat_addsub;
  localparam int W    = 6;
  localparam int SPAN = 1 << W;
  localparam int PMAX = (1 << (W-1)) - 1;
  localparam int NMIN = -(1 << (W-1));

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         op_valid = 1'b0;
  logic         op_sub = 1'b0;
  logic [W-1:0] opnd_a = '0;
  logic [W-1:0] opnd_b = '0;
  logic         sticky_clr = 1'b0;
  logic [W-1:0] res_q;
  logic         res_done, flg_ovf, flg_sovf, flg_aovf, flg_saovf;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [W-1:0] e_res = '0;
  logic e_done = 0, e_ovf = 0, e_sovf = 0, e_aovf = 0, e_saovf = 0;
  string e_tag = "R11";

  always #10 clk = ~clk;

  sat_addsub #(.DATA_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sub(op_sub),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .sticky_clr(sticky_clr),
    .res_q(res_q), .res_done(res_done), .flg_ovf(flg_ovf),
    .flg_sovf(flg_sovf), .flg_aovf(flg_aovf), .flg_saovf(flg_saovf)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(e_tag, int'(res_q), int'(e_res));
    chk("R10 done", int'(res_done), int'(e_done));
    chk("R4 ovf", int'(flg_ovf), int'(e_ovf));
    chk("R5 sovf", int'(flg_sovf), int'(e_sovf));
    chk("R6 aovf", int'(flg_aovf), int'(e_aovf));
    chk("R7 saovf", int'(flg_saovf), int'(e_saovf));
  endtask

  // drive on a falling edge; the model predicts the state after the next rise
  task automatic issue(input bit v, input bit s, input int a, input int b, input bit c);
    int ai, bi, ex, sat_hi, sat_lo, adv;
    op_valid = v; op_sub = s; sticky_clr = c;
    opnd_a = W'(a); opnd_b = W'(b);
    ai = (a >= SPAN/2) ? a - SPAN : a;
    bi = (b >= SPAN/2) ? b - SPAN : b;
    ex = s ? ai - bi : ai + bi;
    sat_hi = (ex > PMAX);
    sat_lo = (ex < NMIN);
    adv = ((ex >>> (W-1)) ^ (ex >>> (W-2))) & 1;
    e_done = v;
    if (v) begin
      if (sat_hi)      begin e_res = W'(PMAX); e_tag = "R2 clamp high"; end
      else if (sat_lo) begin e_res = W'(NMIN); e_tag = "R3 clamp low"; end
      else             begin e_res = W'(ex);   e_tag = "R1 pass"; end
      e_ovf   = (sat_hi || sat_lo);
      e_aovf  = adv[0];
      e_sovf  = e_sovf | e_ovf;
      e_saovf = e_saovf | e_aovf;
    end else begin
      e_tag = "R8 hold";
    end
    if (c) begin
      e_sovf = 0; e_saovf = 0;
      e_tag = {e_tag, " R9"};
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare_all(); // R11 reset state
    rst_n = 1'b1;
    // directed: max + 1 clamps high, then clear together with an overflowing op (R9)
    @(negedge clk); issue(1, 0, PMAX, 1, 0);
    @(negedge clk); compare_all(); issue(1, 1, SPAN/2, 1, 1);
    @(negedge clk); compare_all(); issue(0, 0, 3, 3, 0); // R8 idle after clear
    @(negedge clk); compare_all(); issue(1, 0, 1, 2, 0);
    // exhaustive sweep of both operations with interleaved idle and clear cycles
    for (int a = 0; a < SPAN; a++) begin
      for (int b = 0; b < SPAN; b++) begin
        for (int s = 0; s < 2; s++) begin
          @(negedge clk);
          compare_all();
          issue(((a*3 + b + s) % 29) != 0, s[0], a, b, ((a + b*5 + s) % 37) == 0);
        end
      end
    end
    @(negedge clk); compare_all(); issue(0, 0, 0, 0, 0);
    @(negedge clk); compare_all();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule